// File: doc/BRIEF.md
# Programmable Memory and Peripheral Chip-Select Decoder

This block watches the address of each processor bus cycle and pulls low the matching chip-select line. There are three groups of selects. A low-memory select covers a region that starts at address zero. Four midrange selects split one relocatable memory block into equal quarters. Six peripheral selects each own a 128-byte window in a 1 KB block, which can sit in memory space or in the 16-bit I/O space. The windows are numbered 0 to 3, 5 and 6. Window 4 and window 7 decode to nothing.

Four 16-bit control registers hold the setup of the regions. A group stays dark until software has touched the registers that group depends on. A read counts as a touch, the same as a write. With every asserted select, the block also drives the wait-state count and the external-ready requirement of the winning region, for use by a downstream wait generator. Peripheral selects 5 and 6 can instead be turned into copies of address bits 1 and 2.

Register map, picked by `regSel`:
- 0, low: top bits [15:6] of the region, ready-ignore [2], waits [1:0].
- 1, mid: base [15:9], ready-ignore [2], waits [1:0].
- 2, per: base [15:6], ready-ignore [2], waits [1:0].
- 3, aux: mid size code [9:8], address mode for 5/6 [7], peripheral I/O space [6], ready-ignore for 5/6 [2], waits for 5/6 [1:0].

Top module: `chip_select_unit`

## Requirements
- R1: After reset every select output is high, `waitStates` is 0 and `needExtReady` is 0. Every register reads 0.
- R2: `lowCsN` stays high until register 0 has been read or written. After that it goes low in a valid memory cycle whose `busAddr[19:10]` is less than or equal to register 0 bits [15:6].
- R3: The midrange selects stay high until both register 1 and register 3 have been accessed, in either order.
- R4: The midrange block is 8 KB shifted left by the size code in register 3 bits [9:8]. Register 1 bits [15:9] give `busAddr[19:13]` of its base, and the low size-code bits of that base are ignored. `midCsN[k]` goes low for the k-th equal quarter of the block.
- R5: The peripheral selects stay high until both register 2 and register 3 have been accessed.
- R6: In memory space (register 3 bit 6 = 0), the peripheral block matches when `busAddr[19:10]` equals register 2 bits [15:6]. In I/O space it matches when `busAddr[15:10]` equals register 2 bits [11:6]. Window index `busAddr[9:7]` selects the output: 0–3 drive `perLoCsN[i]`, 5 drives `perCs5N` and 6 drives `perCs6N`. Indices 4 and 7 drive nothing.
- R7: A select is asserted only while `cycleValid` is high and the cycle is in that select's space. Low and midrange selects are memory-only. When `cycleValid` is low, all selects are high.
- R8: At most one select is low at a time. The priority is low, then midrange, then peripheral. A midrange block and an I/O-space peripheral block at the same address both decode, each in its own space.
- R9: With register 3 bit 7 set, `perCs5N` carries `busAddr[1]` and `perCs6N` carries `busAddr[2]` at all times, and neither acts as a select.
- R10: `waitStates` equals bits [1:0] of the winning region's register and `needExtReady` equals the inverse of its bit 2. Selects 5 and 6 take these values from register 3. With no select asserted, both outputs are 0.
- R11: Reading a register returns the last value written to it, on `regRdData`, combinationally from `regSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regSel | input | 2 | Register index |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the register picked by `regSel` |
| cycleValid | input | 1 | A bus cycle is in progress |
| cycleIsIo | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| busAddr | input | 20 | Cycle address; I/O cycles use bits [15:0] |
| lowCsN | output | 1 | Low-memory select |
| midCsN | output | 4 | Midrange selects |
| perLoCsN | output | 4 | Peripheral selects 0–3 |
| perCs5N | output | 1 | Peripheral select 5 or address bit 1 |
| perCs6N | output | 1 | Peripheral select 6 or address bit 2 |
| waitStates | output | 2 | Wait states of the asserted region |
| needExtReady | output | 1 | External ready must be sampled |

## Verification
The assertions assume that `cycleValid`, `cycleIsIo`, `busAddr` and the register strobes are settled before each rising edge. They also assume that no read strobe and write strobe collide on different registers. The bench changes these inputs only on falling edges. It strobes one register per cycle and raises no strobe at the same time as a decode check. It places regions so that any overlap it creates is one the priority rule resolves, which keeps the single-select property meaningful.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int MEM_AW     = 20;
  localparam int IO_AW      = 16;
  localparam int REG_W      = 16;
  localparam int WAIT_W     = 2;
  localparam int LOW_SHIFT  = 10;
  localparam int MID_SHIFT  = 13;
  localparam int MID_SUBS   = 4;
  localparam int PER_SHIFT  = 10;
  localparam int WIN_SHIFT  = 7;
  localparam int PER_LO_N   = 4;
  localparam int SIZE_W     = 2;

  localparam int LOW_TOP_W  = MEM_AW - LOW_SHIFT;
  localparam int MID_BASE_W = MEM_AW - MID_SHIFT;
  localparam int PER_BASE_W = MEM_AW - PER_SHIFT;
  localparam int PER_IO_W   = IO_AW - PER_SHIFT;
  localparam int SUB_W      = $clog2(MID_SUBS);
  localparam int WIN_W      = PER_SHIFT - WIN_SHIFT;
  localparam int SUB_SHIFT  = MID_SHIFT - SUB_W;

  // register field positions
  localparam int RDY_BIT    = 2;
  localparam int AUX_SIZE_LO = 8;
  localparam int AUX_ADDR_BIT = 7;
  localparam int AUX_IO_BIT   = 6;

  typedef enum logic [1:0] {
    REG_LOW = 2'd0,
    REG_MID = 2'd1,
    REG_PER = 2'd2,
    REG_AUX = 2'd3
  } regSel_e;

  typedef struct packed {
    logic                  lowEn;
    logic                  midEn;
    logic                  perEn;
    logic [LOW_TOP_W-1:0]  lowTop;
    logic                  lowRdyIgn;
    logic [WAIT_W-1:0]     lowWait;
    logic [MID_BASE_W-1:0] midBase;
    logic [SIZE_W-1:0]     midSize;
    logic                  midRdyIgn;
    logic [WAIT_W-1:0]     midWait;
    logic [PER_BASE_W-1:0] perBase;
    logic                  perIo;
    logic                  perRdyIgn;
    logic [WAIT_W-1:0]     perWait;
    logic                  p56Addr;
    logic                  p56RdyIgn;
    logic [WAIT_W-1:0]     p56Wait;
  } csuCfg_t;
endpackage

// File: rtl/csu_ctrl.sv
module csu_ctrl
  import csu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [1:0]       regSel,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output csuCfg_t          cfg
);
  logic [REG_W-1:0] lowReg, midReg, perReg, auxReg;
  logic lowSeen, midSeen, perSeen, auxSeen;
  logic regAccess;
  regSel_e selE;

  assign regAccess = regWr | regRd;
  assign selE      = regSel_e'(regSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowReg  <= '0;
      midReg  <= '0;
      perReg  <= '0;
      auxReg  <= '0;
      lowSeen <= 1'b0;
      midSeen <= 1'b0;
      perSeen <= 1'b0;
      auxSeen <= 1'b0;
    end else begin
      if (regWr) begin
        case (selE)
          REG_LOW: lowReg <= regWrData;
          REG_MID: midReg <= regWrData;
          REG_PER: perReg <= regWrData;
          default: auxReg <= regWrData;
        endcase
      end
      if (regAccess) begin
        case (selE)
          REG_LOW: lowSeen <= 1'b1;
          REG_MID: midSeen <= 1'b1;
          REG_PER: perSeen <= 1'b1;
          default: auxSeen <= 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    case (selE)
      REG_LOW: regRdData = lowReg;
      REG_MID: regRdData = midReg;
      REG_PER: regRdData = perReg;
      default: regRdData = auxReg;
    endcase
  end

  always_comb begin
    cfg.lowEn     = lowSeen;
    cfg.midEn     = midSeen & auxSeen;
    cfg.perEn     = perSeen & auxSeen;
    cfg.lowTop    = lowReg[REG_W-1 -: LOW_TOP_W];
    cfg.lowRdyIgn = lowReg[RDY_BIT];
    cfg.lowWait   = lowReg[WAIT_W-1:0];
    cfg.midBase   = midReg[REG_W-1 -: MID_BASE_W];
    cfg.midSize   = auxReg[AUX_SIZE_LO +: SIZE_W];
    cfg.midRdyIgn = midReg[RDY_BIT];
    cfg.midWait   = midReg[WAIT_W-1:0];
    cfg.perBase   = perReg[REG_W-1 -: PER_BASE_W];
    cfg.perIo     = auxReg[AUX_IO_BIT];
    cfg.perRdyIgn = perReg[RDY_BIT];
    cfg.perWait   = perReg[WAIT_W-1:0];
    cfg.p56Addr   = auxReg[AUX_ADDR_BIT];
    cfg.p56RdyIgn = auxReg[RDY_BIT];
    cfg.p56Wait   = auxReg[WAIT_W-1:0];
  end

  // R2: any access to the low register arms the low select
  p_low_arm_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAccess && selE == REG_LOW) |=> cfg.lowEn);

  // R3: once armed, the midrange group stays armed
  p_mid_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfg.midEn |=> cfg.midEn);

  // R5: peripheral group only arms as the result of a register access
  p_per_arm_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfg.perEn) |-> $past(regAccess));
endmodule

// File: rtl/csu_decode.sv
module csu_decode
  import csu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  csuCfg_t              cfg,
  input  logic                 cycleValid,
  input  logic                 cycleIsIo,
  input  logic [MEM_AW-1:0]    busAddr,
  output logic                 lowCsN,
  output logic [MID_SUBS-1:0]  midCsN,
  output logic [PER_LO_N-1:0]  perLoCsN,
  output logic                 perCs5N,
  output logic                 perCs6N,
  output logic [WAIT_W-1:0]    waitStates,
  output logic                 needExtReady
);
  logic memCyc, ioCyc;
  logic lowHit, midHit, perHit, perSpaceOk, perBaseHit;
  logic [MID_BASE_W-1:0] midAddr;
  logic [SUB_W-1:0]      midSub;
  logic [WIN_W-1:0]      winIdx;
  logic [MID_SUBS-1:0]   midSel;
  logic [PER_LO_N-1:0]   perLoSel;
  logic sel5, sel6, anySel;
  logic unusedAddrBits;

  assign unusedAddrBits = ^{busAddr[WIN_SHIFT-1:3], busAddr[0]};

  assign memCyc = cycleValid & ~cycleIsIo;
  assign ioCyc  = cycleValid &  cycleIsIo;

  assign lowHit = cfg.lowEn & memCyc &
                  (busAddr[MEM_AW-1:LOW_SHIFT] <= cfg.lowTop);

  assign midAddr = busAddr[MEM_AW-1:MID_SHIFT];
  assign midHit  = cfg.midEn & memCyc & ~lowHit &
                   ((midAddr >> cfg.midSize) == (cfg.midBase >> cfg.midSize));
  assign midSub  = SUB_W'(busAddr >> (SUB_SHIFT + int'(cfg.midSize)));

  assign perSpaceOk = cfg.perIo ? ioCyc : memCyc;
  assign perBaseHit = cfg.perIo
    ? (busAddr[IO_AW-1:PER_SHIFT] == cfg.perBase[PER_IO_W-1:0])
    : (busAddr[MEM_AW-1:PER_SHIFT] == cfg.perBase);
  assign perHit = cfg.perEn & perSpaceOk & perBaseHit & ~lowHit & ~midHit;
  assign winIdx = busAddr[PER_SHIFT-1:WIN_SHIFT];

  for (genvar k = 0; k < MID_SUBS; k++) begin : g_mid
    assign midSel[k] = midHit & (midSub == SUB_W'(k));
  end

  for (genvar i = 0; i < PER_LO_N; i++) begin : g_per
    assign perLoSel[i] = perHit & (winIdx == WIN_W'(i));
  end

  assign sel5 = perHit & ~cfg.p56Addr & (winIdx == WIN_W'(5));
  assign sel6 = perHit & ~cfg.p56Addr & (winIdx == WIN_W'(6));
  assign anySel = lowHit | (|midSel) | (|perLoSel) | sel5 | sel6;

  assign lowCsN   = ~lowHit;
  assign midCsN   = ~midSel;
  assign perLoCsN = ~perLoSel;
  assign perCs5N  = cfg.p56Addr ? busAddr[1] : ~sel5;
  assign perCs6N  = cfg.p56Addr ? busAddr[2] : ~sel6;

  always_comb begin
    waitStates   = '0;
    needExtReady = 1'b0;
    if (lowHit) begin
      waitStates   = cfg.lowWait;
      needExtReady = ~cfg.lowRdyIgn;
    end else if (|midSel) begin
      waitStates   = cfg.midWait;
      needExtReady = ~cfg.midRdyIgn;
    end else if (|perLoSel) begin
      waitStates   = cfg.perWait;
      needExtReady = ~cfg.perRdyIgn;
    end else if (sel5 | sel6) begin
      waitStates   = cfg.p56Wait;
      needExtReady = ~cfg.p56RdyIgn;
    end
  end

  // R8: never more than one select at a time
  p_one_select_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~lowCsN, ~midCsN, ~perLoCsN, sel5, sel6}) <= 1);

  // R7: outside a bus cycle every select is released
  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cycleValid |-> (lowCsN && (&midCsN) && (&perLoCsN) && !sel5 && !sel6));

  // R7: memory-only groups stay off in I/O cycles
  p_io_no_mem_r7: assert property (@(posedge clk) disable iff (!rstN)
    cycleIsIo |-> (lowCsN && (&midCsN)));

  // R2: unarmed low select stays off
  p_low_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.lowEn |-> lowCsN);

  // R3: unarmed midrange group stays off
  p_mid_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.midEn |-> (&midCsN));

  // R5: unarmed peripheral group stays off
  p_per_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.perEn |-> ((&perLoCsN) && !sel5 && !sel6));

  // R9: in address mode pins 5 and 6 never select
  p_addr_mode_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfg.p56Addr |-> (!sel5 && !sel6));

  // R10: no select means no waits and no ready request
  p_idle_wait_r10: assert property (@(posedge clk) disable iff (!rstN)
    !anySel |-> (waitStates == '0 && !needExtReady));
endmodule

// File: rtl/chip_select_unit.sv
module chip_select_unit
  import csu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [1:0]           regSel,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 cycleValid,
  input  logic                 cycleIsIo,
  input  logic [MEM_AW-1:0]    busAddr,
  output logic                 lowCsN,
  output logic [MID_SUBS-1:0]  midCsN,
  output logic [PER_LO_N-1:0]  perLoCsN,
  output logic                 perCs5N,
  output logic                 perCs6N,
  output logic [WAIT_W-1:0]    waitStates,
  output logic                 needExtReady
);
  csuCfg_t cfg;

  csu_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regRd     (regRd),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cfg       (cfg)
  );

  csu_decode decode_i (
    .clk          (clk),
    .rstN         (rstN),
    .cfg          (cfg),
    .cycleValid   (cycleValid),
    .cycleIsIo    (cycleIsIo),
    .busAddr      (busAddr),
    .lowCsN       (lowCsN),
    .midCsN       (midCsN),
    .perLoCsN     (perLoCsN),
    .perCs5N      (perCs5N),
    .perCs6N      (perCs6N),
    .waitStates   (waitStates),
    .needExtReady (needExtReady)
  );
endmodule

// File: tb/chip_select_unit_tb_top.sv
`timescale 1ns/1ps
module chip_select_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        cycleValid = 1'b0, cycleIsIo = 1'b0;
  logic [19:0] busAddr = 20'h0;
  logic        lowCsN, perCs5N, perCs6N, needExtReady;
  logic [3:0]  midCsN, perLoCsN;
  logic [1:0]  waitStates;

  int nTests = 0;
  int nFail  = 0;
  bit doneRun = 1'b0;

  always #2 clk = ~clk;

  chip_select_unit dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .cycleValid(cycleValid),
    .cycleIsIo(cycleIsIo), .busAddr(busAddr), .lowCsN(lowCsN), .midCsN(midCsN),
    .perLoCsN(perLoCsN), .perCs5N(perCs5N), .perCs6N(perCs6N),
    .waitStates(waitStates), .needExtReady(needExtReady)
  );

  // vector: {isIo, addr, target}; target 0 none, 1 low, 2..5 mid0..3,
  // 6..9 peripheral 0..3, 10 peripheral 5, 11 peripheral 6
  localparam int NVEC = 16;
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 20'h00010, 4'd1},  {1'b0, 20'h00FFF, 4'd1},
    {1'b0, 20'h01000, 4'd0},  {1'b0, 20'h40000, 4'd2},
    {1'b0, 20'h41000, 4'd3},  {1'b0, 20'h42FFE, 4'd4},
    {1'b0, 20'h43FFF, 4'd5},  {1'b0, 20'h44000, 4'd0},
    {1'b0, 20'h80000, 4'd6},  {1'b0, 20'h80180, 4'd9},
    {1'b0, 20'h80200, 4'd0},  {1'b0, 20'h80280, 4'd10},
    {1'b0, 20'h80300, 4'd11}, {1'b0, 20'h80380, 4'd0},
    {1'b1, 20'h40000, 4'd0},  {1'b1, 20'h80000, 4'd0}
  };

  // expected {lowN, midN[3:0], perLoN[3:0], p5N, p6N, waits[1:0], ext}
  function automatic logic [13:0] expOf(input int code, input logic [1:0] w, input logic e);
    logic [10:0] sels;
    sels = '1;
    if (code == 1) sels[10] = 1'b0;
    else if (code >= 2 && code <= 5) sels[9 - (code - 2)] = 1'b0;
    else if (code >= 6 && code <= 9) sels[5 - (code - 6)] = 1'b0;
    else if (code == 10) sels[1] = 1'b0;
    else if (code == 11) sels[0] = 1'b0;
    if (code == 0) return {sels, 3'b000};
    return {sels, w, e};
  endfunction

  function automatic logic [13:0] observed();
    return {lowCsN, midCsN[0], midCsN[1], midCsN[2], midCsN[3],
            perLoCsN[0], perLoCsN[1], perLoCsN[2], perLoCsN[3],
            perCs5N, perCs6N, waitStates, needExtReady};
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic regAccess(input logic wr, input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    regSel = sel; regWrData = data; regWr = wr; regRd = ~wr;
    @(negedge clk);
    regWr = 1'b0; regRd = 1'b0;
  endtask

  task automatic busCycle(input logic valid, input logic io, input logic [19:0] addr);
    @(negedge clk);
    cycleValid = valid; cycleIsIo = io; busAddr = addr;
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!doneRun) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    busCycle(1'b0, 1'b0, 20'h00010);
    check("R1 outputs", {2'b0, observed()}, {2'b0, expOf(0, 2'd0, 1'b0)});
    check("R1 readback", regRdData, 16'h0000);
    // R2: unarmed low select
    busCycle(1'b1, 1'b0, 20'h00010);
    check("R2 unarmed", {2'b0, observed()}, {2'b0, expOf(0, 2'd0, 1'b0)});
    // R2: a read arms it; reset register has waits 0, ready needed
    regAccess(1'b0, 2'd0, 16'h0);
    busCycle(1'b1, 1'b0, 20'h00010);
    check("R2 armed by read", {2'b0, observed()}, {2'b0, expOf(1, 2'd0, 1'b1)});
    // R3: midrange waits for the aux register
    regAccess(1'b1, 2'd0, 16'h00C5);
    regAccess(1'b1, 2'd1, 16'h4002);
    busCycle(1'b1, 1'b0, 20'h40000);
    check("R3 mid unarmed", {2'b0, observed()}, {2'b0, expOf(0, 2'd0, 1'b0)});
    // R5: peripheral waits for the aux register
    regAccess(1'b1, 2'd2, 16'h8000);
    busCycle(1'b1, 1'b0, 20'h80000);
    check("R5 per unarmed", {2'b0, observed()}, {2'b0, expOf(0, 2'd0, 1'b0)});
    regAccess(1'b1, 2'd3, 16'h0107);
    // R2 R4 R6 R10 table walk
    for (int v = 0; v < NVEC; v++) begin
      int code;
      logic [1:0] w;
      logic e;
      code = int'(VEC[v][3:0]);
      if (code == 1) begin w = 2'd1; e = 1'b0; end
      else if (code <= 5) begin w = 2'd2; e = 1'b1; end
      else if (code <= 9) begin w = 2'd0; e = 1'b1; end
      else begin w = 2'd3; e = 1'b0; end
      busCycle(1'b1, VEC[v][24], VEC[v][23:4]);
      check($sformatf("R4 R6 R10 vector %0d", v), {2'b0, observed()}, {2'b0, expOf(code, w, e)});
    end
    // R7: idle cycle
    busCycle(1'b0, 1'b0, 20'h40000);
    check("R7 idle", {2'b0, observed()}, {2'b0, expOf(0, 2'd0, 1'b0)});
    // R8: low wins over an overlapping midrange block at 0
    regAccess(1'b1, 2'd1, 16'h0002);
    busCycle(1'b1, 1'b0, 20'h00010);
    check("R8 low priority", {2'b0, observed()}, {2'b0, expOf(1, 2'd1, 1'b0)});
    busCycle(1'b1, 1'b0, 20'h01000);
    check("R8 mid past low top", {2'b0, observed()}, {2'b0, expOf(3, 2'd2, 1'b1)});
    // R6 R8: peripheral block in I/O space at 0x2000 overlapping midrange
    regAccess(1'b1, 2'd3, 16'h0147);
    regAccess(1'b1, 2'd2, 16'h0200);
    busCycle(1'b1, 1'b0, 20'h02000);
    check("R8 mem side", {2'b0, observed()}, {2'b0, expOf(4, 2'd2, 1'b1)});
    busCycle(1'b1, 1'b1, 20'h02000);
    check("R8 io side", {2'b0, observed()}, {2'b0, expOf(6, 2'd0, 1'b1)});
    busCycle(1'b1, 1'b1, 20'h02080);
    check("R6 io window 1", {2'b0, observed()}, {2'b0, expOf(7, 2'd0, 1'b1)});
    busCycle(1'b1, 1'b1, 20'h02280);
    check("R10 io window 5", {2'b0, observed()}, {2'b0, expOf(10, 2'd3, 1'b0)});
    busCycle(1'b1, 1'b1, 20'h00010);
    check("R7 low is memory only", {2'b0, observed()}, {2'b0, expOf(0, 2'd0, 1'b0)});
    // R9: address mode
    regAccess(1'b1, 2'd3, 16'h01C7);
    busCycle(1'b1, 1'b1, 20'h02282);
    check("R9 addr 1", {2'b0, observed()}, {2'b0, expOf(0, 2'd0, 1'b0) & 14'b11111111110111});
    busCycle(1'b1, 1'b1, 20'h02284);
    check("R9 addr 2", {2'b0, observed()}, {2'b0, expOf(0, 2'd0, 1'b0) & 14'b11111111101111});
    busCycle(1'b0, 1'b0, 20'h00002);
    check("R9 idle addr", {2'b0, observed()}, {2'b0, expOf(0, 2'd0, 1'b0) & 14'b11111111110111});
    // R11: readback
    @(negedge clk); regSel = 2'd1; #1;
    check("R11 mid reg", regRdData, 16'h0002);
    @(negedge clk); regSel = 2'd3; #1;
    check("R11 aux reg", regRdData, 16'h01C7);
    @(negedge clk); regSel = 2'd0; #1;
    check("R11 low reg", regRdData, 16'h00C5);
    doneRun = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule